// File: doc/BRIEF.md
# Scanline Interrupt and Multiplier Register Block

This block sits on the cartridge side of a CPU bus as a small register window. It has two functions. The first is a scanline-compare interrupt: software writes a line number, and an external scanline detector compares against that number and pulses a match input. The block records each match in a status byte and, if interrupts are enabled, raises an active-high IRQ line until software acknowledges it. The second is an unsigned 8×8 multiplier: software writes two operands, then reads the 16-bit product back as two bytes from the same two addresses.

Reading the status byte returns the pending flag and acknowledges it in the same access. A bus access marked side-effect-free (a debugger peek) returns the same data but changes nothing. Reads of offsets that decode to no readable register return the last byte seen on the data bus.

Offset map inside the window: 0 is the compare line (write-only), 1 is status on read and enable on write, 2 is operand A on write and the low product byte on read, and 3 is operand B on write and the high product byte on read.

Top module: `sirq_mul_regs`

## Requirements
- R1: After synchronous reset, the compare line, both operands, the enable and the pending flag are zero, `irq_o` is low and the open-bus byte is 0x00.
- R2: A write to offset 0 stores all 8 data bits as the compare line, which is presented on `cmp_line_o` from the next cycle.
- R3: A write to offset 1 loads the interrupt enable from data bit 7 only. Bits 6:0 of that write have no effect.
- R4: A cycle with `line_hit_i` high sets the pending flag. A read of offset 1 returns the status byte, with the pending flag in bit 7 and zeros in bits 6:0.
- R5: A read of offset 1 with `bus_peek_i` low clears the pending flag after that cycle, so `irq_o` is low from the next cycle. If `line_hit_i` is high in the same cycle, the flag stays set.
- R6: A read of offset 1 with `bus_peek_i` high returns the status byte and leaves the pending flag and `irq_o` unchanged.
- R7: `irq_o` is high exactly when the pending flag and the enable are both set. Clearing the enable drops the line. Setting the enable again while the flag is pending raises it.
- R8: A write to offset 2 loads operand A and a write to offset 3 loads operand B. Reads of offset 2 and offset 3 return bits 7:0 and bits 15:8 of the unsigned product A×B, valid in the cycle after the operand write.
- R9: A read of offset 0 or of any offset above 3 returns the open-bus byte. This byte is the data of the most recent write, or of the most recent read of a readable offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Offset within the register window |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_peek_i | input | 1 | Marks a read as side-effect-free |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the offset |
| line_hit_i | input | 1 | Match pulse from the external scanline detector |
| cmp_line_o | output | 8 | Compare line number for the detector |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench drives a match pulse and an acknowledging status read in the same cycle. A design that lets the clear win would lose an interrupt, and the follow-up peek would read 0x00 where 0x80 is expected. It writes the enable as 0x7F and then as 0x80 around a match. A design that decoded the wrong bit would raise the IRQ line on the first write or miss it on the second. The multiplier is exercised with operands at 0, 1 and 255 and with mixed values, reading both bytes straight after the write so that a stale or swapped product shows. Open-bus reads follow both a write and a product read, which catches a latch that is never refreshed or that tracks only writes.

// File: rtl/sirq_mul_pkg.sv
package sirq_mul_pkg;

    localparam int BUS_W      = 8;
    localparam int PROD_W     = 2 * BUS_W;
    localparam int PEND_BIT   = 7;
    localparam int ENABLE_BIT = 7;

    typedef enum logic [2:0] {
        SEL_CMP,
        SEL_STAT,
        SEL_MUL_LO,
        SEL_MUL_HI,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        logic     peek;
        reg_sel_e sel;
    } bus_req_t;

    function automatic logic sel_readable(input reg_sel_e s);
        return (s == SEL_STAT) || (s == SEL_MUL_LO) || (s == SEL_MUL_HI);
    endfunction

endpackage

// File: rtl/sirq_status_unit.sv
module sirq_status_unit
    import sirq_mul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             hit_i,
    output logic [BUS_W-1:0] cmp_line_o,
    output logic [BUS_W-1:0] status_o,
    output logic             irq_o
);
    logic [BUS_W-1:0] cmp_q;
    logic             en_q;
    logic             pend_q;
    logic             cmp_wr, en_wr, ack;

    assign cmp_wr = req_i.wr && (req_i.sel == SEL_CMP);
    assign en_wr  = req_i.wr && (req_i.sel == SEL_STAT);
    assign ack    = req_i.rd && !req_i.peek && (req_i.sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= wdata_i;
            if (en_wr)  en_q  <= wdata_i[ENABLE_BIT];
            if (hit_i)    pend_q <= 1'b1;
            else if (ack) pend_q <= 1'b0;
        end
    end

    always_comb begin
        status_o           = '0;
        status_o[PEND_BIT] = pend_q;
    end

    assign cmp_line_o = cmp_q;
    assign irq_o      = pend_q && en_q;

    a_r4_hit_sets: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> pend_q);
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit_i) |=> (!pend_q && !irq_o));
    a_r6_peek_keeps: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && req_i.peek && pend_q) |=> pend_q);
    a_r3_enable_bit: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_q == $past(wdata_i[ENABLE_BIT])));
    a_r7_disable_drops: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !wdata_i[ENABLE_BIT]) |=> !irq_o);
    a_r2_cmp_load: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (cmp_line_o == $past(wdata_i)));

endmodule

// File: rtl/sirq_mult_unit.sv
module sirq_mult_unit
    import sirq_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [PROD_W-1:0] prod_o
);
    logic [BUS_W-1:0] op_a_q, op_b_q;
    logic             wr_a, wr_b;

    assign wr_a = req_i.wr && (req_i.sel == SEL_MUL_LO);
    assign wr_b = req_i.wr && (req_i.sel == SEL_MUL_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else begin
            if (wr_a) op_a_q <= wdata_i;
            if (wr_b) op_b_q <= wdata_i;
        end
    end

    assign prod_o = PROD_W'(op_a_q) * PROD_W'(op_b_q);

    a_r8_opa_load: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> (op_a_q == $past(wdata_i)));
    a_r8_opb_load: assert property (@(posedge clk) disable iff (rst)
        wr_b |=> (op_b_q == $past(wdata_i)));
    a_r8_ops_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_i.wr) |=> $stable(prod_o));

endmodule

// File: rtl/sirq_openbus.sv
module sirq_openbus
    import sirq_mul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [BUS_W-1:0] mapped_rdata_i,
    output logic [BUS_W-1:0] last_o
);
    logic [BUS_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (req_i.wr)
            last_q <= wdata_i;
        else if (req_i.rd && sel_readable(req_i.sel))
            last_q <= mapped_rdata_i;
    end

    assign last_o = last_q;

    a_r9_latch_write: assert property (@(posedge clk) disable iff (rst)
        req_i.wr |=> (last_o == $past(wdata_i)));
    a_r9_latch_idle: assert property (@(posedge clk) disable iff (rst)
        (!req_i.wr && !req_i.rd) |=> $stable(last_o));

endmodule

// File: rtl/sirq_mul_regs.sv
module sirq_mul_regs
    import sirq_mul_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int OFF_CMP    = 0,
    parameter int OFF_STAT   = 1,
    parameter int OFF_MUL_LO = 2,
    parameter int OFF_MUL_HI = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic              bus_peek_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              line_hit_i,
    output logic [7:0]        cmp_line_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFF_CMP);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_MUL_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_MUL_HI);

    bus_req_t          req;
    logic [BUS_W-1:0]  status, last_byte, mapped;
    logic [PROD_W-1:0] prod;

    always_comb begin
        req.wr   = bus_wr_i;
        req.rd   = bus_rd_i;
        req.peek = bus_peek_i;
        if      (bus_addr_i == A_CMP) req.sel = SEL_CMP;
        else if (bus_addr_i == A_ST)  req.sel = SEL_STAT;
        else if (bus_addr_i == A_LO)  req.sel = SEL_MUL_LO;
        else if (bus_addr_i == A_HI)  req.sel = SEL_MUL_HI;
        else                          req.sel = SEL_NONE;
    end

    sirq_status_unit u_status (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .wdata_i    (bus_wdata_i),
        .hit_i      (line_hit_i),
        .cmp_line_o (cmp_line_o),
        .status_o   (status),
        .irq_o      (irq_o)
    );

    sirq_mult_unit u_mult (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .wdata_i (bus_wdata_i),
        .prod_o  (prod)
    );

    always_comb begin
        case (req.sel)
            SEL_STAT:   mapped = status;
            SEL_MUL_LO: mapped = prod[BUS_W-1:0];
            SEL_MUL_HI: mapped = prod[PROD_W-1:BUS_W];
            default:    mapped = last_byte;
        endcase
    end

    sirq_openbus u_openbus (
        .clk            (clk),
        .rst            (rst),
        .req_i          (req),
        .wdata_i        (bus_wdata_i),
        .mapped_rdata_i (mapped),
        .last_o         (last_byte)
    );

    assign bus_rdata_o = mapped;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq_o && cmp_line_o == 8'h00));
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && !sel_readable(req.sel)) |-> (bus_rdata_o == last_byte));

endmodule

// File: tb/sirq_mul_regs_tb.sv
module sirq_mul_regs_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0, peek = 1'b0, hit = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, cmp_line;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sirq_mul_regs u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr_i (addr),
        .bus_wr_i   (wr),
        .bus_rd_i   (rd),
        .bus_peek_i (peek),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .line_hit_i (hit),
        .cmp_line_o (cmp_line),
        .irq_o      (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic pk, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1; peek = pk;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0; peek = 1'b0;
    endtask

    task automatic pulse_hit();
        @(negedge clk);
        hit = 1'b1;
        @(negedge clk);
        hit = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", 16'(irq), 16'h0);
        check("R1 cmp_line", 16'(cmp_line), 16'h0);
        bus_read(4'd9, 1'b1, d);  check("R1 openbus", 16'(d), 16'h00);
        bus_read(4'd1, 1'b1, d);  check("R1 status", 16'(d), 16'h00);
        bus_read(4'd2, 1'b0, d);  check("R1 prod lo", 16'(d), 16'h00);
        bus_read(4'd3, 1'b0, d);  check("R1 prod hi", 16'(d), 16'h00);
    endtask

    task automatic t_compare();
        bus_write(4'd0, 8'hC5); check("R2 cmp C5", 16'(cmp_line), 16'hC5);
        bus_write(4'd0, 8'hFF); check("R2 cmp FF", 16'(cmp_line), 16'hFF);
        bus_write(4'd0, 8'h01); check("R2 cmp 01", 16'(cmp_line), 16'h01);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        bus_write(4'd1, 8'h7F);
        pulse_hit();
        check("R3 low bits do not enable", 16'(irq), 16'h0);
        bus_read(4'd1, 1'b1, d); check("R4 status after hit", 16'(d), 16'h80);
        bus_read(4'd1, 1'b0, d); check("R5 ack read value", 16'(d), 16'h80);
        bus_write(4'd1, 8'h80);
        check("R3 enable, nothing pending", 16'(irq), 16'h0);
        pulse_hit();
        check("R7 irq on hit", 16'(irq), 16'h1);
    endtask

    task automatic t_peek();
        logic [7:0] d;
        bus_read(4'd1, 1'b1, d); check("R6 peek value", 16'(d), 16'h80);
        check("R6 irq kept", 16'(irq), 16'h1);
        bus_read(4'd1, 1'b1, d); check("R6 peek again", 16'(d), 16'h80);
    endtask

    task automatic t_gate();
        bus_write(4'd1, 8'h00); check("R7 disable drops irq", 16'(irq), 16'h0);
        bus_write(4'd1, 8'h80); check("R7 re-enable raises irq", 16'(irq), 16'h1);
    endtask

    task automatic t_ack();
        logic [7:0] d;
        bus_read(4'd1, 1'b0, d); check("R5 ack value", 16'(d), 16'h80);
        check("R5 irq cleared", 16'(irq), 16'h0);
        bus_read(4'd1, 1'b1, d); check("R5 status cleared", 16'(d), 16'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        addr = 4'd1; rd = 1'b1; peek = 1'b0; hit = 1'b1;
        #1 check("R5 collide read", 16'(rdata), 16'h00);
        @(negedge clk);
        rd = 1'b0; hit = 1'b0;
        check("R5 hit wins irq", 16'(irq), 16'h1);
        bus_read(4'd1, 1'b1, d); check("R5 hit wins status", 16'(d), 16'h80);
        bus_read(4'd1, 1'b0, d);
    endtask

    task automatic t_mult(input logic [7:0] a, input logic [7:0] b);
        logic [7:0]  lo, hi;
        logic [15:0] exp;
        exp = 16'(a) * 16'(b);
        bus_write(4'd2, a);
        bus_write(4'd3, b);
        bus_read(4'd2, 1'b0, lo);
        bus_read(4'd3, 1'b0, hi);
        check("R8 product", {hi, lo}, exp);
    endtask

    task automatic t_openbus();
        logic [7:0] d, v;
        bus_write(4'd2, 8'h5A);
        bus_read(4'd7, 1'b0, d);  check("R9 after write", 16'(d), 16'h5A);
        bus_write(4'd3, 8'h07);
        bus_read(4'd3, 1'b0, v);  check("R9 prod hi 5A*07", 16'(v), 16'h02);
        bus_read(4'd15, 1'b0, d); check("R9 after mapped read", 16'(d), 16'(v));
        bus_read(4'd0, 1'b0, d);  check("R9 compare offset", 16'(d), 16'(v));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_compare();
        t_enable();
        t_peek();
        t_gate();
        t_ack();
        t_collide();
        t_mult(8'd0,   8'd0);
        t_mult(8'd255, 8'd255);
        t_mult(8'd13,  8'd17);
        t_mult(8'd200, 8'd3);
        t_mult(8'd1,   8'd255);
        t_openbus();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule